// File: doc/BRIEF.md
# Serial Daisy-Chain Configuration Node

This block is the configuration front end of one device that sits in a serial configuration daisy chain. All devices in the chain share three lines: the configuration clock, the active-low program line, and a wired-AND done line. The serial data output of each device feeds the serial data input of the next device. After a program pulse, the node scans the incoming bit stream for a 32-bit alignment pattern. It then takes a fixed number of payload bits into its own configuration memory. The memory sees these bits as a stream of words with addresses.

While the node is filling, its data output stays high, so devices further down the chain see an idle line. Once its memory is full, the node becomes a one-register pass-through. From then on, every later bit goes to the next device, including that device's own alignment pattern. The node lets go of the shared done line as soon as it is full. It enters startup only when the shared line actually reads high. That happens after every device in the chain has let go, so the whole chain starts up together.

Top module: `cfg_chain_node`

## Requirements
- R1: While `prog_n` is low at a clock edge, the node restarts. After that edge `ser_out`=1, `mem_full`=0, `done_pull_low`=1, `startup`=0 and `mem_we`=0.
- R2: Before alignment, the node compares the last 32 received bits with `ALIGN_WORD`. The earliest bit received is the MSB. The window starts at all zeros, so `ALIGN_WORD` must not be zero. The bit sampled on the edge after the first match is payload bit 0, even when a partial copy of the pattern came just before the match.
- R3: Every `WORD_BITS` payload bits, `mem_we` is high for exactly one cycle, after the edge that samples the last bit of the word. `mem_data` then holds that word with its first-received bit in the MSB. `mem_addr` is 0 for the first word and goes up by one for each later word.
- R4: `mem_full` rises after the edge that samples payload bit `PAYLOAD_BITS-1`. It stays high until the next program pulse.
- R5: From restart until `mem_full` is high, `ser_out` is 1, whatever arrives on `ser_in`.
- R6: After a clock edge at which `mem_full` was already high, `ser_out` equals the `ser_in` value sampled at that edge. That is a lag of one clock. This includes any alignment pattern meant for downstream devices.
- R7: `done_pull_low` is high exactly while `mem_full` is low.
- R8: `startup` rises after the first edge at which both `mem_full` and `done_line` are high. It then stays high until a program pulse. While `done_line` is low, `startup` stays 0 even when the node is full.
- R9: Once aligned, the node does no further pattern matching. An alignment pattern inside the payload is stored as ordinary data.
- R10: A program pulse in the middle of loading drops the partly loaded state. A following stream is then aligned and loaded from scratch, starting again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock |
| prog_n | input | 1 | Shared program line, synchronous active-low restart |
| ser_in | input | 1 | Serial configuration data from the previous device |
| ser_out | output | 1 | Serial data to the next device, registered |
| done_line | input | 1 | Sampled level of the shared wired-AND done line |
| done_pull_low | output | 1 | 1 while this node holds the shared done line low |
| mem_we | output | 1 | Configuration memory word write strobe |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_data | output | WORD_BITS | Word being written |
| mem_full | output | 1 | Payload complete; forwarding active |
| startup | output | 1 | Chain-wide startup reached |

## Verification
A wrong alignment point would show up at the ports quickly. It would shift the data on the very first `mem_we` pulse by the size of the error, and it would also move the cycle in which `mem_full` rises. A payload counter that is off by one would change that `mem_full` edge, and with it the first forwarded bit on `ser_out`, which arrives one cycle later. A word counter or address fault shows up at the next write strobe. A pass-through that runs too early shows a non-one value on `ser_out` during loading. The done logic is checked by holding the shared line low after the node is full, and then checking that `startup` rises one edge after the line is released.

// File: rtl/cfg_chain_pkg.sv
// Shared types for the daisy-chain configuration node.
// Assumes: a single clock domain (the shared configuration clock).
package cfg_chain_pkg;

    typedef enum logic [1:0] {
        NODE_HUNT = 2'd0,   // scanning for the alignment pattern
        NODE_LOAD = 2'd1,   // absorbing payload bits
        NODE_FULL = 2'd2    // memory full, forwarding the stream
    } node_state_t;

endpackage

// File: rtl/ccn_align_detect.sv
// Sliding-window alignment detector.
// Shifts one bit per enabled clock (the earliest bit ends up in the MSB).
// The hit output is combinational on the current bit.
// Assumes: PATTERN is non-zero, because the window restarts at zero.
module ccn_align_detect #(
    parameter int          PAT_BITS = 32,
    parameter logic [PAT_BITS-1:0] PATTERN = 32'hC3A5_1E7B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_in,
    output logic hit
);
    logic [PAT_BITS-1:0] window_q;
    logic [PAT_BITS-1:0] window_nxt;

    // Candidate window including the bit on the input now.
    assign window_nxt = {window_q[PAT_BITS-2:0], bit_in};
    assign hit        = enable && (window_nxt == PATTERN);

    // Shift the window while hunting; clear it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            window_q <= '0;
        else if (enable)
            window_q <= window_nxt;
    end
endmodule

// File: rtl/ccn_payload_load.sv
// Payload absorber: assembles serial bits into words MSB-first.
// Emits a one-cycle write strobe per word, with word addresses counting up from 0.
// Flags the cycle in which the final payload bit arrives.
// Assumes: WORD_BITS >= 2 and PAYLOAD_BITS is a multiple of WORD_BITS.
module ccn_payload_load #(
    parameter int PAYLOAD_BITS = 64,
    parameter int WORD_BITS    = 8,
    parameter int ADDR_W       = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic                 bit_in,
    output logic                 last_bit,
    output logic                 we,
    output logic [ADDR_W-1:0]    addr,
    output logic [WORD_BITS-1:0] data
);
    localparam int CNT_W = $clog2(PAYLOAD_BITS + 1);
    localparam int WC_W  = $clog2(WORD_BITS);

    logic [CNT_W-1:0]     bit_cnt_q;
    logic [WC_W-1:0]      word_bit_q;
    logic [WORD_BITS-1:0] shift_q;
    logic [WORD_BITS-1:0] shift_nxt;
    logic [ADDR_W-1:0]    next_addr_q;

    assign shift_nxt = {shift_q[WORD_BITS-2:0], bit_in};
    assign last_bit  = load_en && (bit_cnt_q == CNT_W'(PAYLOAD_BITS - 1));

    // Count payload bits so the top level can tell when the memory is full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt_q <= '0;
        else if (load_en)
            bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // Assemble words and issue one write strobe per completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_bit_q  <= '0;
            shift_q     <= '0;
            next_addr_q <= '0;
            we          <= 1'b0;
            addr        <= '0;
            data        <= '0;
        end else begin
            we <= 1'b0;
            if (load_en) begin
                shift_q <= shift_nxt;
                if (word_bit_q == WC_W'(WORD_BITS - 1)) begin
                    word_bit_q  <= '0;
                    we          <= 1'b1;
                    data        <= shift_nxt;
                    addr        <= next_addr_q;
                    next_addr_q <= next_addr_q + 1'b1;
                end else begin
                    word_bit_q <= word_bit_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ccn_forward.sv
// Pass-through stage toward the next device.
// Holds the output high until forwarding is enabled. After that it
// repeats the input with one register of delay.
module ccn_forward (
    input  logic clk,
    input  logic rst_n,
    input  logic fwd_en,
    input  logic bit_in,
    output logic bit_out
);
    // Idle-high until full, then copy the input one clock late.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_out <= 1'b1;
        else
            bit_out <= fwd_en ? bit_in : 1'b1;
    end
endmodule

// File: rtl/ccn_startup.sv
// Done-line handling: holds the shared wired-AND line low until this node
// is full. Latches startup once it is full and the sampled line reads high.
// Assumes: done_line is already synchronous to clk.
module ccn_startup (
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic done_line,
    output logic pull_low,
    output logic started
);
    assign pull_low = !full;

    // Sticky startup flag, gated by the chain-wide done level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            started <= 1'b0;
        else if (full && done_line)
            started <= 1'b1;
    end
endmodule

// File: rtl/cfg_chain_node.sv
// One device's configuration front end in a serial daisy chain.
// Sequence: hunt for the alignment pattern, load PAYLOAD_BITS bits into
// memory words, then forward the rest of the stream and wait for the
// shared done line before startup.
// Assumes: prog_n is synchronous to clk, and all inputs share the clk domain.
module cfg_chain_node #(
    parameter logic [31:0] ALIGN_WORD   = 32'hC3A5_1E7B,
    parameter int          PAYLOAD_BITS = 64,
    parameter int          WORD_BITS    = 8,
    localparam int         WORDS        = PAYLOAD_BITS / WORD_BITS,
    localparam int         ADDR_W       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 prog_n,
    input  logic                 ser_in,
    output logic                 ser_out,
    input  logic                 done_line,
    output logic                 done_pull_low,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_BITS-1:0] mem_data,
    output logic                 mem_full,
    output logic                 startup
);
    import cfg_chain_pkg::*;

    node_state_t state_q;
    logic        align_hit;
    logic        last_bit;
    logic        hunting;
    logic        loading;

    assign hunting  = (state_q == NODE_HUNT);
    assign loading  = (state_q == NODE_LOAD);
    assign mem_full = (state_q == NODE_FULL);

    // Phase sequencing: hunt -> load -> full; only a program pulse returns to hunt.
    always_ff @(posedge clk) begin
        if (!prog_n)
            state_q <= NODE_HUNT;
        else begin
            case (state_q)
                NODE_HUNT: if (align_hit) state_q <= NODE_LOAD;
                NODE_LOAD: if (last_bit)  state_q <= NODE_FULL;
                default:                  state_q <= NODE_FULL;
            endcase
        end
    end

    ccn_align_detect #(
        .PAT_BITS (32),
        .PATTERN  (ALIGN_WORD)
    ) u_align (
        .clk    (clk),
        .rst_n  (prog_n),
        .enable (hunting),
        .bit_in (ser_in),
        .hit    (align_hit)
    );

    ccn_payload_load #(
        .PAYLOAD_BITS (PAYLOAD_BITS),
        .WORD_BITS    (WORD_BITS),
        .ADDR_W       (ADDR_W)
    ) u_load (
        .clk      (clk),
        .rst_n    (prog_n),
        .load_en  (loading),
        .bit_in   (ser_in),
        .last_bit (last_bit),
        .we       (mem_we),
        .addr     (mem_addr),
        .data     (mem_data)
    );

    ccn_forward u_fwd (
        .clk     (clk),
        .rst_n   (prog_n),
        .fwd_en  (mem_full),
        .bit_in  (ser_in),
        .bit_out (ser_out)
    );

    ccn_startup u_start (
        .clk       (clk),
        .rst_n     (prog_n),
        .full      (mem_full),
        .done_line (done_line),
        .pull_low  (done_pull_low),
        .started   (startup)
    );
endmodule

// File: rtl/cfg_chain_node_chk.sv
// Port-level property checker for cfg_chain_node, attached by bind.
module cfg_chain_node_chk (
    input logic clk,
    input logic prog_n,
    input logic ser_in,
    input logic ser_out,
    input logic done_line,
    input logic done_pull_low,
    input logic mem_we,
    input logic mem_full,
    input logic startup
);
    // R5: idle-high output before the memory is full
    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!prog_n)
        !mem_full |=> ser_out);

    // R6: one-clock forwarding once full
    assert_forward_lag_R6: assert property (@(posedge clk) disable iff (!prog_n)
        mem_full |=> (ser_out == $past(ser_in)));

    // R4: full is sticky until program
    assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!prog_n)
        mem_full |=> mem_full);

    // R7: done drive released exactly when full
    assert_done_drive_R7: assert property (@(posedge clk) disable iff (!prog_n)
        done_pull_low != mem_full);

    // R8: startup needs full and a high done line on the previous edge
    assert_startup_gate_R8: assert property (@(posedge clk) disable iff (!prog_n)
        $rose(startup) |-> ($past(mem_full) && $past(done_line)));

    // R8: startup is sticky
    assert_startup_sticky_R8: assert property (@(posedge clk) disable iff (!prog_n)
        startup |=> startup);

    // R3: a write strobe lasts one cycle
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!prog_n)
        mem_we |=> !mem_we);
endmodule

bind cfg_chain_node cfg_chain_node_chk u_chk (
    .clk           (clk),
    .prog_n        (prog_n),
    .ser_in        (ser_in),
    .ser_out       (ser_out),
    .done_line     (done_line),
    .done_pull_low (done_pull_low),
    .mem_we        (mem_we),
    .mem_full      (mem_full),
    .startup       (startup)
);

// File: tb/cfg_chain_node_tb.sv
// Self-checking bench: streams built from random and directed content.
// Expected values come from the requirement rules applied to the stream.
module cfg_chain_node_tb_top;
    localparam logic [31:0] SYNC = 32'hC3A5_1E7B;
    localparam int P      = 64;
    localparam int W      = 8;
    localparam int ADDR_W = 3;
    localparam int MAXLEN = 512;

    logic clk = 1'b0;
    logic prog_n = 1'b0;
    logic ser_in = 1'b0;
    logic done_line = 1'b0;
    logic ser_out, done_pull_low, mem_we, mem_full, startup;
    logic [ADDR_W-1:0] mem_addr;
    logic [W-1:0] mem_data;

    int checks = 0;
    int failures = 0;
    logic s [MAXLEN];

    always #10 clk = ~clk;

    cfg_chain_node #(.ALIGN_WORD(SYNC), .PAYLOAD_BITS(P), .WORD_BITS(W)) dut_i (
        .clk(clk), .prog_n(prog_n), .ser_in(ser_in), .ser_out(ser_out),
        .done_line(done_line), .done_pull_low(done_pull_low),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_full(mem_full), .startup(startup));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Index of the bit that completes the first alignment match (R2), or -1.
    function automatic int first_align(int len);
        logic [31:0] win = '0;
        for (int t = 0; t < len; t++) begin
            win = {win[30:0], s[t]};
            if (win == SYNC) return t;
        end
        return -1;
    endfunction

    function automatic logic [W-1:0] word_at(int t);
        logic [W-1:0] w = '0;
        for (int k = 0; k < W; k++) w = {w[W-2:0], s[t-W+1+k]};
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        prog_n = 1'b0; done_line = 1'b0; ser_in = 1'b0;
        @(posedge clk); #2;
        check("R1 ser_out", ser_out, 1);
        check("R1 mem_full", mem_full, 0);
        check("R1 done_pull_low", done_pull_low, 1);
        check("R1 startup", startup, 0);
        check("R1 mem_we", mem_we, 0);
        @(negedge clk);
        prog_n = 1'b1;
    endtask

    // Stream s[0..len-1]; other devices ready from ready_at; stop early at stop_at.
    task automatic run_stream(int len, int ready_at, int stop_at);
        int e = first_align(len);
        logic exp_full = 1'b0;
        logic exp_start = 1'b0;
        for (int t = 0; t < len && t < stop_at; t++) begin
            logic dl;
            logic exp_we;
            @(negedge clk);
            ser_in = s[t];
            dl = (t >= ready_at) && exp_full;
            done_line = dl;
            @(posedge clk); #2;
            exp_start = exp_start | (exp_full & dl);
            exp_full  = (e >= 0) && (t >= e + P);
            exp_we    = (e >= 0) && (t > e) && (t <= e + P) && (((t - e) % W) == 0);
            check("R4 mem_full", mem_full, exp_full);
            check("R7 done_pull_low", done_pull_low, !exp_full);
            check("R8 startup", startup, exp_start);
            if ((e >= 0) && (t >= e + P + 1))
                check("R6 forward", ser_out, s[t]);
            else
                check("R5 idle high", ser_out, 1);
            check("R3 mem_we", mem_we, exp_we);
            if (exp_we && mem_we) begin
                check("R3 R9 mem_data", mem_data, word_at(t));
                check("R3 R10 mem_addr", mem_addr, (t - e) / W - 1);
            end
        end
    endtask

    task automatic put_sync(int at);
        for (int k = 0; k < 32; k++) s[at + k] = SYNC[31-k];
    endtask

    task automatic fill_rand(int from, int n);
        for (int k = 0; k < n; k++) s[from + k] = 1'($urandom);
    endtask

    task automatic run_all();
        int noise, tail, len;
        void'($urandom(32'd1234));
        // Random trials (R2..R8)
        for (int tr = 0; tr < 5; tr++) begin
            do_reset();
            noise = 5 + int'($urandom % 36);
            tail  = 30 + int'($urandom % 51);
            fill_rand(0, noise);
            put_sync(noise);
            fill_rand(noise + 32, P + tail);
            len = noise + 32 + P + tail;
            run_stream(len, int'($urandom % len), MAXLEN);
        end
        // R2: partial pattern prefix directly before the real one
        do_reset();
        for (int k = 0; k < 20; k++) s[k] = SYNC[31-k];
        put_sync(20);
        fill_rand(52, P + 40);
        run_stream(52 + P + 40, 0, MAXLEN);
        // R9 and R8: pattern inside payload; done line held low throughout
        do_reset();
        fill_rand(0, 7);
        put_sync(7);
        fill_rand(39, 8);
        put_sync(47);
        fill_rand(79, P - 40 + 30);
        run_stream(39 + P + 30, MAXLEN, MAXLEN);
        check("R8 startup held by done line", startup, 0);
        // R5: no pattern at all, output stays high
        do_reset();
        for (int k = 0; k < 80; k++) s[k] = 1'b1;
        run_stream(80, 0, MAXLEN);
        // R10: program pulse mid-load, then a fresh stream
        do_reset();
        fill_rand(0, 10);
        put_sync(10);
        fill_rand(42, P + 20);
        run_stream(42 + P + 20, 0, 42 + 20);
        do_reset();
        fill_rand(0, 3);
        put_sync(3);
        fill_rand(35, P + 25);
        run_stream(35 + P + 25, 10, MAXLEN);
    endtask

    initial begin
        fork
            run_all();
            begin
                #(20 * 200000);
                failures++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule